// File: doc/BRIEF.md
# Predicated Vector Compare Mask Unit

This unit turns one scalar compare-and-branch into a walk over up to VL element pairs. One element is compared per clock. Each outcome lands in a bit of a result mask, gated by a source predicate. When a destination predicate register is present, the finished mask is handed out with a write strobe. The branch decision is that the finished mask equals the source predicate. When neither source is flagged as a vector, the unit makes one ordinary scalar compare and branches on it.

The surrounding pipeline supplies the operands. The unit shows the element it is working on (`elem_idx`), and the pipeline presents that element on `elem_a` and `elem_b` in the same cycle. A source flagged as scalar is sampled once, in the start cycle. After that the unit reuses the sampled value for every element. A trap can stop the walk at any element. When a destination exists, the partly built mask is handed out for saving. Otherwise the caller simply reissues the compare, which begins again at element 0.

Top module: `vcmp_mask_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mask_we`, `branch_taken` and `mask_out` are all 0.
- R2: `cmp_op` codes are 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than and 5 unsigned greater-or-equal. Codes 6 and 7 always give false.
- R3: When `src1_vec` and `src2_vec` are both 0 at start, the unit compares `elem_a` with `elem_b` as presented in the start cycle. In the next cycle `done` is 1 and `branch_taken` equals the compare result. `mask_we` stays 0 and `mask_out` is 0.
- R4: In vector mode the mask starts at 0 when `dst_exists` is 0 or `zeroing` is 1. Otherwise it starts at `dst_old`.
- R5: For each element i below the effective VL:
  - If predicate bit i is 1, mask bit i becomes the compare result.
  - If predicate bit i is 0, mask bit i is cleared when zeroing and kept otherwise.
  - Mask bits at or above the effective VL keep their start value.
- R6: A source flagged as vector uses the stream value present while `elem_idx` equals i. A source flagged as scalar uses the value sampled at start, and later stream values on that source have no effect.
- R7: In vector mode with effective VL n ≥ 1, `done` pulses n+1 cycles after the start cycle. With n = 0, it pulses in the next cycle. With `done`:
  - `mask_out` shows the final mask.
  - `mask_we` equals `dst_exists`.
  - `branch_taken` is 1 exactly when the full-width final mask equals `pred_mask`.
- R8: A `trap` seen while `busy` stops the walk at that edge. The element due at that edge is not applied, and `done` does not pulse. If a destination exists, `mask_we` pulses in the next cycle with the partial mask on `mask_out`. If none exists, `mask_we` stays 0. A trap arriving on the edge of the last element wins over completion.
- R9: Every start, including one after a trap, begins at element 0 with a freshly built start mask.
- R10: `start` while `busy` is ignored, including new configuration values, and `trap` while idle has no effect.
- R11: A `vl` above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a compare (accepted when idle) |
| trap | input | 1 | Abort the walk in progress |
| vl | input | VLW | Element count, clamped to MAX_VL |
| src1_vec | input | 1 | First source is a vector |
| src2_vec | input | 1 | Second source is a vector |
| cmp_op | input | 3 | Compare type code |
| pred_mask | input | MAX_VL | Source predicate |
| zeroing | input | 1 | Clear predicated-out bits |
| dst_exists | input | 1 | A destination predicate register is present |
| dst_old | input | MAX_VL | Current value of the destination register |
| elem_a | input | DATA_W | First source operand stream |
| elem_b | input | DATA_W | Second source operand stream |
| busy | output | 1 | Element walk in progress |
| elem_idx | output | VLW | Element expected on the streams this cycle |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | MAX_VL | Final or partial mask |
| mask_we | output | 1 | Write strobe for the destination register |
| branch_taken | output | 1 | Branch decision, valid with `done` |

## Verification
Two functions can meet on one clock edge: applying the last element, which would raise `done`, and a trap that halts the walk. The bench raises `trap` on every element edge of a four-element walk, including the final one, with and without a destination. It expects no `done` pulse and a partial mask that leaves out the element due at the trap edge. A second overlap is a new `start` arriving mid-walk. That is judged by requiring the original result at the original latency.

// File: rtl/vcmp_pkg.sv
// Package: compare type codes shared by the compare unit and its users.
// Assumes a 3-bit compare code; codes without a name compare as false.
package vcmp_pkg;
    localparam int CMP_OP_W = 3;

    typedef enum logic [CMP_OP_W-1:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_LT  = 3'd2,
        CMP_GE  = 3'd3,
        CMP_LTU = 3'd4,
        CMP_GEU = 3'd5
    } cmp_op_e;
endpackage

// File: rtl/vcmp_cmp.sv
// Module: single-element comparator.
// Evaluates one operand pair under the selected compare type, purely
// combinationally. Assumes operands of DATA_W bits in two's complement
// for the signed codes.
module vcmp_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [vcmp_pkg::CMP_OP_W-1:0] op,
    input  logic [DATA_W-1:0]             a,
    input  logic [DATA_W-1:0]             b,
    output logic                          res
);
    import vcmp_pkg::*;

    // Select the outcome of the requested relation.
    always_comb begin
        case (cmp_op_e'(op))
            CMP_EQ:  res = (a == b);
            CMP_NE:  res = (a != b);
            CMP_LT:  res = ($signed(a) <  $signed(b));
            CMP_GE:  res = ($signed(a) >= $signed(b));
            CMP_LTU: res = (a <  b);
            CMP_GEU: res = (a >= b);
            default: res = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcmp_ctrl.sv
// Module: element walk sequencer.
// Accepts a start when idle, clamps the element count, and steps an
// index one element per cycle. A trap while busy aborts the walk, and
// it takes priority over the step on that edge. Assumes start and trap
// are synchronous single-cycle or level inputs.
module vcmp_ctrl #(
    parameter int MAX_VL = 16,
    parameter int VLW    = $clog2(MAX_VL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           trap,
    input  logic [VLW-1:0] vl,
    input  logic           any_vec,
    output logic           busy,
    output logic [VLW-1:0] idx,
    output logic [VLW-1:0] vl_lat,
    output logic           launch,
    output logic           step,
    output logic           last,
    output logic           abort,
    output logic           vl_zero
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

    logic [VLW-1:0] vl_eff;

    // Clamp the requested count and derive the per-cycle controls.
    always_comb begin
        vl_eff  = (vl > VL_CAP) ? VL_CAP : vl;
        launch  = start && !busy;
        abort   = busy && trap;
        step    = busy && !trap;
        last    = step && (idx == vl_lat - VLW'(1));
        vl_zero = launch && any_vec && (vl_eff == '0);
    end

    // Walk state: run flag, element index and latched count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            vl_lat <= '0;
        end else if (launch) begin
            vl_lat <= vl_eff;
            idx    <= '0;
            busy   <= any_vec && (vl_eff != '0);
        end else if (abort) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (step) begin
            if (last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + VLW'(1);
            end
        end
    end
endmodule

// File: rtl/vcmp_opsel.sv
// Module: operand selector.
// Samples the source kind flags and the stream values at launch. During
// the walk it feeds the live stream for a vector source and the sampled
// value for a scalar source. In the launch cycle it passes the raw
// streams, which the scalar-only compare uses.
module vcmp_opsel #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              src1_vec,
    input  logic              src2_vec,
    input  logic [DATA_W-1:0] elem_a,
    input  logic [DATA_W-1:0] elem_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    logic              v1_q, v2_q;
    logic [DATA_W-1:0] sa_q, sb_q;

    // Hold the source kinds and the scalar operand values for the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            sa_q <= '0;
            sb_q <= '0;
        end else if (launch) begin
            v1_q <= src1_vec;
            v2_q <= src2_vec;
            sa_q <= elem_a;
            sb_q <= elem_b;
        end
    end

    // Route the live stream or the held scalar to the comparator.
    always_comb begin
        op_a = (launch || v1_q) ? elem_a : sa_q;
        op_b = (launch || v2_q) ? elem_b : sb_q;
    end
endmodule

// File: rtl/vcmp_mask.sv
// Module: mask accumulator and result register.
// Builds the start mask, applies one element result per step under the
// latched predicate, and produces done, the write strobe and the branch
// decision. Assumes idx < MAX_VL whenever step is high.
module vcmp_mask #(
    parameter int MAX_VL = 16,
    parameter int VLW    = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              any_vec,
    input  logic              vl_zero,
    input  logic              step,
    input  logic              last,
    input  logic              abort,
    input  logic [VLW-1:0]    idx,
    input  logic [MAX_VL-1:0] pred_mask,
    input  logic              zeroing,
    input  logic              dst_exists,
    input  logic [MAX_VL-1:0] dst_old,
    input  logic              cmp_res,
    output logic              done,
    output logic [MAX_VL-1:0] mask_out,
    output logic              mask_we,
    output logic              branch_taken,
    output logic              dst_lat
);
    logic [MAX_VL-1:0] acc, nxt, init, pred_q;
    logic              zero_q;

    // Start value: prior destination contents unless absent or zeroing.
    always_comb begin
        init = (dst_exists && !zeroing) ? dst_old : '0;
    end

    // Per-bit update: only the bit at the current index may change.
    for (genvar b = 0; b < MAX_VL; b++) begin : g_bit
        always_comb begin
            if (idx == VLW'(b))
                nxt[b] = pred_q[b] ? cmp_res : (zero_q ? 1'b0 : acc[b]);
            else
                nxt[b] = acc[b];
        end
    end

    // Accumulator and result registers, with pulses cleared by default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc          <= '0;
            pred_q       <= '0;
            zero_q       <= 1'b0;
            dst_lat      <= 1'b0;
            done         <= 1'b0;
            mask_we      <= 1'b0;
            mask_out     <= '0;
            branch_taken <= 1'b0;
        end else begin
            done    <= 1'b0;
            mask_we <= 1'b0;
            if (launch) begin
                acc     <= init;
                pred_q  <= pred_mask;
                zero_q  <= zeroing;
                dst_lat <= dst_exists && any_vec;
                if (!any_vec) begin
                    done         <= 1'b1;
                    branch_taken <= cmp_res;
                    mask_out     <= '0;
                end else if (vl_zero) begin
                    done         <= 1'b1;
                    mask_out     <= init;
                    mask_we      <= dst_exists;
                    branch_taken <= (init == pred_mask);
                end else begin
                    branch_taken <= 1'b0;
                end
            end else if (abort) begin
                mask_we <= dst_lat;
                if (dst_lat)
                    mask_out <= acc;
            end else if (step) begin
                acc <= nxt;
                if (last) begin
                    done         <= 1'b1;
                    mask_out     <= nxt;
                    mask_we      <= dst_lat;
                    branch_taken <= (nxt == pred_q);
                end
            end
        end
    end
endmodule

// File: rtl/vcmp_mask_unit.sv
// Module: predicated vector compare mask unit (top).
// Walks VL element pairs one per cycle, builds a predicated result mask,
// hands it out for a destination predicate register, and decides the
// branch. Falls back to a single scalar compare when no source is a
// vector. Assumes the pipeline presents element elem_idx on the streams.
module vcmp_mask_unit #(
    parameter int DATA_W = 16,
    parameter int MAX_VL = 16,
    parameter int VLW    = $clog2(MAX_VL + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          trap,
    input  logic [VLW-1:0]                vl,
    input  logic                          src1_vec,
    input  logic                          src2_vec,
    input  logic [vcmp_pkg::CMP_OP_W-1:0] cmp_op,
    input  logic [MAX_VL-1:0]             pred_mask,
    input  logic                          zeroing,
    input  logic                          dst_exists,
    input  logic [MAX_VL-1:0]             dst_old,
    input  logic [DATA_W-1:0]             elem_a,
    input  logic [DATA_W-1:0]             elem_b,
    output logic                          busy,
    output logic [VLW-1:0]                elem_idx,
    output logic                          done,
    output logic [MAX_VL-1:0]             mask_out,
    output logic                          mask_we,
    output logic                          branch_taken
);
    logic              any_vec, launch, step, last, abort, vl_zero, cmp_res, dst_lat;
    logic [VLW-1:0]    vl_lat;
    logic [DATA_W-1:0] op_a, op_b;
    logic [vcmp_pkg::CMP_OP_W-1:0] op_q;

    // Vector mode is chosen when either source is flagged as a vector.
    always_comb begin
        any_vec = src1_vec || src2_vec;
    end

    // Hold the compare type for the whole walk.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_q <= '0;
        else if (launch)
            op_q <= cmp_op;
    end

    vcmp_ctrl #(.MAX_VL(MAX_VL), .VLW(VLW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .trap(trap), .vl(vl),
        .any_vec(any_vec), .busy(busy), .idx(elem_idx), .vl_lat(vl_lat),
        .launch(launch), .step(step), .last(last), .abort(abort),
        .vl_zero(vl_zero)
    );

    vcmp_opsel #(.DATA_W(DATA_W)) u_opsel (
        .clk(clk), .rst_n(rst_n), .launch(launch), .src1_vec(src1_vec),
        .src2_vec(src2_vec), .elem_a(elem_a), .elem_b(elem_b),
        .op_a(op_a), .op_b(op_b)
    );

    vcmp_cmp #(.DATA_W(DATA_W)) u_cmp (
        .op(launch ? cmp_op : op_q), .a(op_a), .b(op_b), .res(cmp_res)
    );

    vcmp_mask #(.MAX_VL(MAX_VL), .VLW(VLW)) u_mask (
        .clk(clk), .rst_n(rst_n), .launch(launch), .any_vec(any_vec),
        .vl_zero(vl_zero), .step(step), .last(last), .abort(abort),
        .idx(elem_idx), .pred_mask(pred_mask), .zeroing(zeroing),
        .dst_exists(dst_exists), .dst_old(dst_old), .cmp_res(cmp_res),
        .done(done), .mask_out(mask_out), .mask_we(mask_we),
        .branch_taken(branch_taken), .dst_lat(dst_lat)
    );
endmodule

// File: rtl/vcmp_mask_unit_chk.sv
// Module: protocol checker for the compare mask unit, bound to the top.
// Observes ports and the latched count and destination flag.
module vcmp_mask_unit_chk #(
    parameter int VLW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           trap,
    input logic           src1_vec,
    input logic           src2_vec,
    input logic           busy,
    input logic           done,
    input logic           mask_we,
    input logic [VLW-1:0] elem_idx,
    input logic [VLW-1:0] vl_lat,
    input logic           dst_lat
);
    // R3: a scalar-only start completes next cycle without a mask write.
    p_scalar_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !src1_vec && !src2_vec) |=> (done && !mask_we));

    // R5: the walk index stays inside the latched element count.
    p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elem_idx < vl_lat));

    // R7: stepping past the last element produces done.
    p_last_gives_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trap && (elem_idx == vl_lat - VLW'(1))) |=> done);

    // R7: a write strobe only appears when a destination was latched.
    p_write_needs_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> dst_lat);

    // R8: a trap while busy ends the walk with no completion.
    p_trap_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trap) |=> (!done && !busy));

    // R9: every walk begins at element 0.
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (elem_idx == '0));

    // R10: a start during the walk leaves the latched count alone.
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(vl_lat));
endmodule

bind vcmp_mask_unit vcmp_mask_unit_chk #(.VLW(VLW)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .trap(trap),
    .src1_vec(src1_vec), .src2_vec(src2_vec), .busy(busy), .done(done),
    .mask_we(mask_we), .elem_idx(elem_idx), .vl_lat(vl_lat),
    .dst_lat(dst_lat)
);

// File: tb/test_vcmp_mask_unit.sv
// Bench: sweeps over a 4-bit, 4-element configuration of the unit.
module test_vcmp_mask_unit;
    localparam int DW  = 4;
    localparam int MVL = 4;
    localparam int VW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic           start = 1'b0, trap = 1'b0;
    logic [VW-1:0]  cfg_vl = '0;
    logic           s1v = 1'b0, s2v = 1'b0, cfg_zero = 1'b0, cfg_dsx = 1'b0;
    logic [2:0]     cfg_op = '0;
    logic [MVL-1:0] cfg_pred = '0, cfg_dold = '0;
    logic [DW-1:0]  sa = '0, sb = '0;
    logic [DW-1:0]  va [0:MVL-1];
    logic [DW-1:0]  vb [0:MVL-1];
    logic [DW-1:0]  elem_a, elem_b;
    logic           busy, done, mask_we, branch_taken;
    logic [VW-1:0]  elem_idx;
    logic [MVL-1:0] mask_out;

    int n_chk = 0, n_err = 0;
    logic [MVL-1:0] exp_mask;
    logic           exp_br;

    vcmp_mask_unit #(.DATA_W(DW), .MAX_VL(MVL)) i_vcmp_mask_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .trap(trap), .vl(cfg_vl),
        .src1_vec(s1v), .src2_vec(s2v), .cmp_op(cfg_op), .pred_mask(cfg_pred),
        .zeroing(cfg_zero), .dst_exists(cfg_dsx), .dst_old(cfg_dold),
        .elem_a(elem_a), .elem_b(elem_b), .busy(busy), .elem_idx(elem_idx),
        .done(done), .mask_out(mask_out), .mask_we(mask_we),
        .branch_taken(branch_taken)
    );

    // Streams: element values while busy; a scalar source shows junk then (R6).
    always_comb begin
        elem_a = busy ? (s1v ? va[elem_idx[1:0]] : ~sa) : sa;
        elem_b = busy ? (s2v ? vb[elem_idx[1:0]] : ~sb) : sb;
    end

    function automatic logic cmp_ref(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) <  $signed(b);
            3'd3: return $signed(a) >= $signed(b);
            3'd4: return a <  b;
            3'd5: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int eff_vl();
        return (int'(cfg_vl) > MVL) ? MVL : int'(cfg_vl);
    endfunction

    // Reference for the first n elements of a vector walk (R4, R5).
    task automatic model_vec(input int n);
        logic [DW-1:0] a, b;
        exp_mask = (cfg_dsx && !cfg_zero) ? cfg_dold : '0;
        for (int i = 0; i < n; i++) begin
            a = s1v ? va[i] : sa;
            b = s2v ? vb[i] : sb;
            if (cfg_pred[i]) exp_mask[i] = cmp_ref(cfg_op, a, b);
            else if (cfg_zero) exp_mask[i] = 1'b0;
        end
        exp_br = (exp_mask == cfg_pred);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for done and return the cycle count since the start cycle.
    task automatic wait_done(output int cyc);
        cyc = 1;
        @(negedge clk);
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // One full run with the current configuration and its checks.
    task automatic run_one(input string tag);
        int cyc, lat;
        logic vec;
        vec = s1v | s2v;
        if (vec) begin
            model_vec(eff_vl());
            lat = (eff_vl() == 0) ? 1 : eff_vl() + 1;
        end else begin
            exp_mask = '0;
            exp_br   = cmp_ref(cfg_op, sa, sb);
            lat      = 1;
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (busy) check({tag, " R9 first index"}, int'(elem_idx), 0);
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, vec ? " R7 latency" : " R3 latency"}, cyc, lat);
        check({tag, vec ? " R5 mask" : " R3 mask"}, int'(mask_out), int'(exp_mask));
        check({tag, vec ? " R7 write" : " R3 write"}, int'(mask_we), vec ? int'(cfg_dsx) : 0);
        check({tag, vec ? " R7 branch" : " R2 branch"}, int'(branch_taken), int'(exp_br));
    endtask

    // Trap after k processed elements of a 4-element walk (R8, R9).
    task automatic trap_run(input int k, input logic dsx);
        s1v = 1'b1; s2v = 1'b1; cfg_vl = 3'd4; cfg_op = 3'd4;
        cfg_pred = 4'b1011; cfg_zero = 1'b0; cfg_dsx = dsx; cfg_dold = 4'b0110;
        for (int i = 0; i < MVL; i++) begin va[i] = DW'(i); vb[i] = DW'(2); end
        model_vec(k);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < k; i++) @(negedge clk);
        trap = 1'b1;
        @(negedge clk);
        trap = 1'b0;
        check("R8 trap no done", int'(done), 0);
        check("R8 trap stops walk", int'(busy), 0);
        check("R8 trap write", int'(mask_we), int'(dsx));
        if (dsx) check("R8 partial mask", int'(mask_out), int'(exp_mask));
        run_one("after trap R9");
    endtask

    int c;
    initial begin
        for (int i = 0; i < MVL; i++) begin va[i] = '0; vb[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 mask_we", int'(mask_we), 0);
        check("R1 mask_out", int'(mask_out), 0);
        check("R1 branch", int'(branch_taken), 0);

        // Scalar sweep over every code and operand pair (R2, R3).
        s1v = 1'b0; s2v = 1'b0;
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    cfg_op = 3'(op); sa = 4'(a); sb = 4'(b);
                    cfg_dsx = 1'((a + b) & 1);
                    run_one("scalar");
                end

        // Vector sweep: counts, predicates, zeroing, destination (R4-R7, R11).
        c = 0;
        for (int v = 0; v < 8; v++)
            for (int p = 0; p < 16; p++)
                for (int z = 0; z < 2; z++)
                    for (int d = 0; d < 2; d++) begin
                        c++;
                        cfg_vl = 3'(v); cfg_pred = 4'(p); cfg_zero = 1'(z); cfg_dsx = 1'(d);
                        cfg_op = 3'(c % 6); cfg_dold = 4'(c * 5);
                        s1v = (c % 3) != 1; s2v = (c % 3) != 0;
                        sa = 4'(c * 3); sb = 4'(c * 7 + 1);
                        for (int i = 0; i < MVL; i++) begin
                            va[i] = 4'(c + i * 5);
                            vb[i] = 4'(c * 3 + i * 9);
                        end
                        run_one(v > MVL ? "vector R11" : "vector R6");
                    end

        // Trap at each element edge, last edge included (R8).
        for (int k = 0; k < 4; k++) begin
            trap_run(k, 1'b1);
            trap_run(k, 1'b0);
        end

        // Start during a walk is ignored (R10).
        s1v = 1'b1; s2v = 1'b0; cfg_vl = 3'd4; cfg_op = 3'd2; sb = 4'd0;
        cfg_pred = 4'b1111; cfg_zero = 1'b0; cfg_dsx = 1'b1; cfg_dold = 4'b0000;
        for (int i = 0; i < MVL; i++) va[i] = 4'(i * 6);
        model_vec(4);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        start = 1'b1; cfg_vl = 3'd1; cfg_pred = 4'b0000; cfg_zero = 1'b1;
        @(negedge clk); start = 1'b0;
        c = 3;
        while (!done && c < 20) begin @(negedge clk); c++; end
        check("R10 latency kept", c, 5);
        check("R10 mask kept", int'(mask_out), int'(exp_mask));
        check("R10 branch kept", int'(branch_taken), int'(exp_br));

        // Trap while idle has no effect (R10).
        @(negedge clk); trap = 1'b1;
        @(negedge clk); trap = 1'b0;
        check("R10 idle trap write", int'(mask_we), 0);
        check("R10 idle trap done", int'(done), 0);
        cfg_vl = 3'd2; cfg_pred = 4'b0011; cfg_zero = 1'b0;
        run_one("idle trap R10");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule